// File: doc/BRIEF.md
# Dual-Clock FIFO with First-Word-Fall-Through Option

This block carries 36-bit words from one clock domain to another through a 256-entry buffer. The producer and the consumer each run on their own clock, and the two clocks need not be related. Each side sees a single status flag that is registered in its own domain. The pointer that crosses from the other side passes through a two-flop synchronizer as a Gray code, so only one bit of it changes per step.

A static mode input chooses how the read side behaves. In standard mode the read flag means "not empty". The output register is not loaded until the consumer asks for a word, and the requested word appears after that read edge. In fall-through mode the read flag means "a word is waiting in the output register". The oldest word is loaded on its own, and the consumer takes it by pulsing the read enable. On the write side the flag always means "a write on this edge is accepted".

Top module: `async_fwft_fifo`

## Requirements
- R1: Every accepted word is delivered on `rd_data` exactly once, in write order, in both modes and for any ratio of the two clock rates.
- R2: A write attempted while `wr_room` is low changes nothing. The stored contents and the order of later reads are the same as if the attempt had not been made.
- R3: With no reads, exactly 256 writes are accepted in standard mode and 257 in fall-through mode, where one extra word sits in the output register. `wr_room` goes low on the write-clock edge that takes the last free slot.
- R4: In standard mode, after one word is written into an empty buffer, `rd_avail` rises no earlier than the 2nd and no later than the 4th rising `rd_clk` edge after the write edge.
- R5: In standard mode no word is preloaded. `rd_data` changes only after a rising `rd_clk` edge where `rd_en` and `rd_avail` are both high. A read request made while `rd_avail` is low is ignored.
- R6: In fall-through mode, the oldest word is already on `rd_data` on the same `rd_clk` edge that raises `rd_avail`.
- R7: In fall-through mode, while `rd_avail` is high and `rd_en` is low, `rd_data` and `rd_avail` hold. A read edge shows the next word, or drops `rd_avail` when no other word is stored.
- R8: In fall-through mode, `rd_en` while `rd_avail` is low has no effect, and the next word written is the next one shown.
- R9: Reset discards all stored words. During and after reset `rd_avail` is low and `rd_data` is zero. `wr_room` is low during reset and high from the first `wr_clk` edge after `wr_rst` is released.
- R10: After the consumer drains a full buffer, `wr_room` comes back high without any write-side action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_room | output | 1 | High when a write on the next edge is accepted |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| fwft_mode | input | 1 | 1 = fall-through, 0 = standard; static outside reset |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word |
| rd_avail | output | 1 | Standard: not empty. Fall-through: output word valid |

## Verification
The properties assume that `fwft_mode` changes only while both resets are held. They also assume each reset is held for several edges of both clocks, so that the synchronizers clear before the mode is used. The stimulus changes the mode only inside such a reset window and releases each reset at a falling edge of its own clock. Requests are driven away from rising edges, which keeps the "request while flag low" cases well defined.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } mode_e;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int DW = 36,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rgray_s,
  output logic        we,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        room
);
  logic [AW:0] wbin, wbin_nxt, wgray_nxt, full_pat;
  logic        full_q;

  assign we        = wr_en & ~full_q;
  assign wbin_nxt  = wbin + {{AW{1'b0}}, we};
  assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  assign full_pat  = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b1;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wgray_nxt;
      full_q <= (wgray_nxt == full_pat);
    end
  end

  assign waddr = wbin[AW-1:0];
  assign room  = ~full_q;
endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
  import afifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          avail
);
  logic [AW:0] rbin, rbin_nxt, rgray_nxt;
  logic        stored, nempty_q, valid_q;

  assign stored = (rgray != wgray_s);

  always_comb begin
    if (mode == MODE_FWFT) re = stored & (~valid_q | rd_en);
    else                   re = rd_en & nempty_q;
  end

  assign rbin_nxt  = rbin + {{AW{1'b0}}, re};
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      nempty_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= rgray_nxt;
      nempty_q <= (rgray_nxt != wgray_s);
      if (re)         valid_q <= 1'b1;
      else if (rd_en) valid_q <= 1'b0;
    end
  end

  assign raddr = rbin[AW-1:0];
  assign avail = (mode == MODE_FWFT) ? valid_q : nempty_q;
endmodule

// File: rtl/async_fwft_fifo.sv
module async_fwft_fifo #(
  parameter int DATA_W      = 36,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_room,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              fwft_mode,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail
);
  logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;

  afifo_wr_ctrl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .room(wr_room)
  );

  afifo_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  afifo_sync #(.W(ADDR_W+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  afifo_rd_ctrl #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .mode(afifo_pkg::mode_e'(fwft_mode)),
    .rd_en(rd_en), .wgray_s(wgray_s), .re(re), .raddr(raddr),
    .rgray(rgray), .avail(rd_avail)
  );

  afifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/async_fwft_fifo_chk.sv
module async_fwft_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 8
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en,
  input logic              wr_room,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              fwft_mode,
  input logic              rd_en,
  input logic              rd_avail,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wgray,
  input logic [ADDR_W:0]   rgray
);
  assert_wgray_step_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R1: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_full_blocks_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !wr_room) |=> $stable(wgray));

  assert_std_hold_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!fwft_mode && !(rd_en && rd_avail)) |=> $stable(rd_data));

  assert_fwft_hold_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (fwft_mode && rd_avail && !rd_en) |=> (rd_avail && $stable(rd_data)));

  assert_fwft_idle_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (fwft_mode && !rd_avail) |=> (rd_avail || $stable(rgray)));

  assert_rst_rd_R9: assert property (@(posedge rd_clk)
    rd_rst |=> !rd_avail);

  assert_rst_wr_R9: assert property (@(posedge wr_clk)
    wr_rst |=> !wr_room);
endmodule

bind async_fwft_fifo async_fwft_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_room(wr_room),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .fwft_mode(fwft_mode), .rd_en(rd_en),
  .rd_avail(rd_avail), .rd_data(rd_data), .wgray(wgray), .rgray(rgray)
);

// File: tb/async_fwft_fifo_tb_top.sv
`timescale 1ns/10ps
module async_fwft_fifo_tb_top;
  localparam int DW = 36;

  // vector: [27] mode, [26:17] words, [16:13] write gap, [12:9] read gap, [8:0] rd half period x0.1ns
  localparam logic [27:0] VECS [6] = '{
    {1'b0, 10'd300, 4'd0, 4'd0, 9'd37},
    {1'b0, 10'd300, 4'd0, 4'd2, 9'd83},
    {1'b0, 10'd200, 4'd3, 4'd0, 9'd61},
    {1'b1, 10'd300, 4'd0, 4'd0, 9'd37},
    {1'b1, 10'd300, 4'd0, 4'd2, 9'd83},
    {1'b1, 10'd200, 4'd2, 4'd1, 9'd49}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  real  rd_half = 3.7;
  logic wr_rst = 1'b1, rd_rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, fwft_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_room, rd_avail;
  logic [DW-1:0] q [$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  async_fwft_fifo dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .fwft_mode(fwft_mode), .rd_en(rd_en),
    .rd_data(rd_data), .rd_avail(rd_avail)
  );

  function automatic logic [DW-1:0] word(input int i);
    return {4'(i) ^ 4'h9, 16'(i * 7 + 3), ~16'(i)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset(input bit m);
    wr_en = 0; rd_en = 0; wr_rst = 1; rd_rst = 1; fwft_mode = m;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    q.delete();
    @(negedge wr_clk) wr_rst = 0;
    @(negedge rd_clk) rd_rst = 0;
    repeat (4) @(negedge rd_clk);
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic push_words(input int n, input int gap, input int base);
    int i = 0, gc = 0;
    while (i < n) begin
      @(negedge wr_clk);
      if (wr_room && gc == 0) begin
        wr_en = 1; wr_data = word(base + i); q.push_back(wr_data); i++; gc = gap;
      end else begin
        wr_en = 0;
        if (gc > 0) gc--;
      end
    end
    @(negedge wr_clk) wr_en = 0;
  endtask

  task automatic pop_words(input int n, input int gap, input string req);
    int got = 0, gc = 0;
    bit pend = 0;
    logic [DW-1:0] exp;
    while (got < n) begin
      @(negedge rd_clk);
      if (!fwft_mode) begin
        if (pend) begin
          exp = q.pop_front();
          check(rd_data == exp, req, rd_data, exp);
          got++; pend = 0;
        end
        rd_en = 0;
        if (got < n) begin
          if (gc > 0) gc--;
          else if (rd_avail) begin rd_en = 1; pend = 1; gc = gap; end
        end
      end else begin
        rd_en = 0;
        if (rd_avail) begin
          if (q.size() == 0) check(0, req, rd_data, '0);
          else begin
            check(rd_data == q[0], req, rd_data, q[0]);
            if (gc == 0) begin rd_en = 1; void'(q.pop_front()); got++; gc = gap; end
            else gc--;
          end
        end
      end
    end
    @(negedge rd_clk) rd_en = 0;
  endtask

  task automatic capacity(input bit m);
    int cnt = 0;
    do_reset(m);
    repeat (700) begin
      @(negedge wr_clk);
      if (wr_room) begin
        wr_en = 1; wr_data = word(5000 + cnt); q.push_back(wr_data); cnt++;
      end else wr_en = 0;
    end
    check(cnt == (m ? 257 : 256), "R3", DW'(cnt), DW'(m ? 257 : 256));
    check(wr_room == 0, "R3", DW'(wr_room), 0);
    // attempts while full must vanish (R2)
    wr_data = '1; wr_en = 1;
    repeat (4) @(negedge wr_clk);
    wr_en = 0;
    pop_words(cnt, 0, "R2");
    check(q.size() == 0, "R2", DW'(q.size()), 0);
    repeat (8) @(negedge wr_clk);
    check(wr_room == 1, "R10", DW'(wr_room), 1);
    repeat (6) @(negedge rd_clk);
    check(rd_avail == 0, "R2", DW'(rd_avail), 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state and first write-side edge after release
    wr_rst = 1; rd_rst = 1;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    check(wr_room == 0, "R9", DW'(wr_room), 0);
    @(negedge rd_clk);
    check(rd_avail == 0, "R9", DW'(rd_avail), 0);
    check(rd_data == '0, "R9", rd_data, '0);
    @(negedge wr_clk) wr_rst = 0;
    @(negedge wr_clk);
    check(wr_room == 1, "R9", DW'(wr_room), 1);
    @(negedge rd_clk) rd_rst = 0;
    repeat (3) @(negedge rd_clk);
    check(rd_avail == 0, "R9", DW'(rd_avail), 0);

    // table of streams: R1 (and R7 drop after last word)
    for (int v = 0; v < 6; v++) begin
      logic [27:0] e;
      e = VECS[v];
      rd_half = real'(e[8:0]) / 10.0;
      do_reset(e[27]);
      fork
        push_words(int'(e[26:17]), int'(e[16:13]), v * 1000);
        pop_words(int'(e[26:17]), int'(e[12:9]), "R1");
      join
      check(q.size() == 0, "R1", DW'(q.size()), 0);
      repeat (6) @(negedge rd_clk);
      check(rd_avail == 0, e[27] ? "R7" : "R1", DW'(rd_avail), 0);
    end
    rd_half = 3.7;

    // R4 and R5: standard latency and no preload
    begin
      int n = 0;
      do_reset(0);
      @(negedge wr_clk) begin wr_en = 1; wr_data = word(77); q.push_back(wr_data); end
      @(posedge wr_clk);
      fork begin @(negedge wr_clk) wr_en = 0; end join_none
      do begin
        @(posedge rd_clk); n++;
        @(negedge rd_clk);
      end while (!rd_avail && n < 20);
      check(n >= 2 && n <= 4, "R4", DW'(n), 3);
      repeat (3) @(negedge rd_clk);
      check(rd_data == '0, "R5", rd_data, '0);
      pop_words(1, 0, "R5");
    end

    // R5: read while empty ignored in standard mode
    do_reset(0);
    rd_en = 1;
    repeat (5) @(negedge rd_clk);
    rd_en = 0;
    check(rd_data == '0, "R5", rd_data, '0);
    push_words(2, 0, 300);
    repeat (6) @(negedge rd_clk);
    check(rd_avail == 1, "R5", DW'(rd_avail), 1);
    check(rd_data == '0, "R5", rd_data, '0);
    pop_words(2, 0, "R5");

    // R6 and R7: fall-through first word and hold
    do_reset(1);
    push_words(1, 0, 400);
    while (!rd_avail) @(negedge rd_clk);
    check(rd_data == word(400), "R6", rd_data, word(400));
    repeat (5) @(negedge rd_clk);
    check(rd_avail == 1 && rd_data == word(400), "R7", rd_data, word(400));
    pop_words(1, 0, "R7");
    @(negedge rd_clk);
    check(rd_avail == 0, "R7", DW'(rd_avail), 0);

    // R8: read while nothing shown is ignored
    do_reset(1);
    rd_en = 1;
    repeat (5) @(negedge rd_clk);
    rd_en = 0;
    push_words(2, 0, 500);
    while (!rd_avail) @(negedge rd_clk);
    check(rd_data == word(500), "R8", rd_data, word(500));
    pop_words(2, 0, "R8");
    check(q.size() == 0, "R8", DW'(q.size()), 0);

    // R2, R3, R10: fill to capacity in both modes
    capacity(0);
    capacity(1);

    // R9: reset mid-stream discards contents
    do_reset(0);
    push_words(5, 0, 600);
    repeat (8) @(negedge rd_clk);
    do_reset(0);
    check(rd_avail == 0, "R9", DW'(rd_avail), 0);
    push_words(1, 0, 700);
    pop_words(1, 0, "R9");
    repeat (6) @(negedge rd_clk);
    check(rd_avail == 0, "R9", DW'(rd_avail), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule